// File: doc/BRIEF.md
# Section Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading one 32-bit descriptor from a translation table in memory. It takes a request over a valid/ready handshake. It builds the descriptor address from a table base register and the top twelve virtual address bits. It reads that one word through a simple read port, decodes the descriptor and returns a result over a second valid/ready handshake. The table base is a physical address, and the descriptor read itself is never translated.

Only one megabyte section descriptors are translated in full. A descriptor that points to a second-level table is reported with its own status, so that a later stage can finish the walk. Every other descriptor type is reported as a fault. When translation is switched off, a request is answered without any memory read and the address comes back unchanged. One walk is in flight at a time. The result stays on the outputs until the consumer takes it.

Top module: `sect_xlate_walker`

## Requirements
- R1: A request accepted while `xlateEn` is low is answered with `rspPa` equal to the virtual address, `rspStatus` 2'b00, `rspCacheable` 1 and `rspSuper` 0, and no memory read is issued.
- R2: With translation on, the read address is the base with virtual bits [31:20] placed at bits [13:2] and bits [1:0] set to zero. This equals base + 4 × va[31:20]. With base 0x00004000 and va 0x12345678, the address is 0x0000448C.
- R3: A base write clears the low 14 bits of the written value. Index 4095 therefore reads the word at base + 0x3FFC.
- R4: A base write made while `reqReady` is low has no effect. Later walks still use the earlier base.
- R5: A descriptor with bits [1:0] = 2'b10 yields `rspStatus` 2'b00 and `rspPa` = {descriptor[31:20], va[19:0]}. For example, descriptor 0xABC00002 with va 0x12345678 gives 0xABC45678.
- R6: A descriptor with bits [1:0] = 2'b01 yields `rspStatus` 2'b01 (second level needed), with `rspPa` 0, `rspCacheable` 0 and `rspSuper` 0.
- R7: A descriptor with bits [1:0] = 2'b00 or 2'b11 yields `rspStatus` 2'b10 (fault), with `rspPa` 0, `rspCacheable` 0 and `rspSuper` 0.
- R8: For a section, `rspCacheable` reports descriptor bit 3 and `rspSuper` reports descriptor bit 18. Bit 18 has no effect on `rspPa`.
- R9: `reqReady` is low from the acceptance of a request until its response handshake completes. While `memRdValid` is high and `memRdReady` is low, `memRdValid` and `memRdAddr` stay unchanged.
- R10: While `rspValid` is high and `rspReady` is low, every response output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xlateEn | input | 1 | Translation on; sampled when a request is accepted |
| baseWrEn | input | 1 | Table base write strobe |
| baseWrData | input | 32 | Table base value to write |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request ready (block idle) |
| reqVa | input | 32 | Virtual address |
| memRdValid | output | 1 | Descriptor read request |
| memRdReady | input | 1 | Memory accepts the read |
| memRdAddr | output | 32 | Physical descriptor address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Descriptor word |
| rspValid | output | 1 | Result valid |
| rspReady | input | 1 | Consumer takes the result |
| rspPa | output | 32 | Physical address |
| rspStatus | output | 2 | 00 ok, 01 second level needed, 10 fault |
| rspCacheable | output | 1 | Cacheable attribute |
| rspSuper | output | 1 | Supersection flag of a section |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 20-bit section offset, the cacheable flag at bit 3 and the supersection flag at bit 18. With these values the two table edges can be reached. Index 0 reads the word at the base itself, and index 4095 reads the last word of a 16 KB table, here placed behind a base written with all of its low 14 bits set. The read port and the result port both stall in repeating patterns. This exposes the hold behaviour on each of them and lets a base write land while a walk is in progress.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xwState_t;

  typedef enum logic [1:0] {
    XS_OK    = 2'b00,
    XS_NEXT  = 2'b01,
    XS_FAULT = 2'b10
  } xwStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptVa;
    logic loadBypass;
    logic loadDesc;
    logic writeBase;
  } xwStrobe_t;

endpackage

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       xlateEn,
  input  logic       baseWrEn,
  input  logic       memRdReady,
  input  logic       memRspValid,
  input  logic       rspReady,
  output logic       reqReady,
  output logic       memRdValid,
  output logic       rspValid,
  output xwStrobe_t  stb
);

  xwState_t state, stateNext;
  logic accept;

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = (state == ST_FETCH);
  assign rspValid   = (state == ST_RESP);
  assign accept     = reqValid && reqReady;

  always_comb begin
    stb.acceptVa   = accept;
    stb.loadBypass = accept && !xlateEn;
    stb.loadDesc   = (state == ST_WAIT) && memRspValid;
    stb.writeBase  = baseWrEn && (state == ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = xlateEn ? ST_FETCH : ST_RESP;
      ST_FETCH: if (memRdReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_RESP;
      ST_RESP:  if (rspReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R9: ready only comes back through a completed response handshake
  a_r9_ready_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> $past(rspValid && rspReady));

  // R1: a bypass load never leads to a memory read
  a_r1_bypass_no_read: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadBypass |=> rspValid && !memRdValid);

endmodule

// File: rtl/xw_datapath.sv
module xw_datapath
  import xw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFS_W    = 20,
  parameter int CACHE_POS = 3,
  parameter int SUPER_POS = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  xwStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] rspPa,
  output logic [1:0]        rspStatus,
  output logic              rspCacheable,
  output logic              rspSuper
);

  localparam int IDX_W   = ADDR_W - OFFS_W;
  localparam int ALIGN_W = IDX_W + 2;
  localparam int BASE_W  = ADDR_W - ALIGN_W;

  logic [BASE_W-1:0] baseHi;
  logic [ADDR_W-1:0] vaReg;
  xwStatus_t         statusReg;

  assign memRdAddr = {baseHi, vaReg[ADDR_W-1:OFFS_W], 2'b00};
  assign rspStatus = statusReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi       <= '0;
      vaReg        <= '0;
      rspPa        <= '0;
      statusReg    <= XS_OK;
      rspCacheable <= 1'b0;
      rspSuper     <= 1'b0;
    end else begin
      if (stb.writeBase) baseHi <= baseWrData[ADDR_W-1:ALIGN_W];
      if (stb.acceptVa)  vaReg  <= reqVa;
      if (stb.loadBypass) begin
        rspPa        <= reqVa;
        statusReg    <= XS_OK;
        rspCacheable <= 1'b1;
        rspSuper     <= 1'b0;
      end else if (stb.loadDesc) begin
        rspPa        <= '0;
        rspCacheable <= 1'b0;
        rspSuper     <= 1'b0;
        unique case (memRspData[1:0])
          2'b10: begin
            statusReg    <= XS_OK;
            rspPa        <= {memRspData[ADDR_W-1:OFFS_W], vaReg[OFFS_W-1:0]};
            rspCacheable <= memRspData[CACHE_POS];
            rspSuper     <= memRspData[SUPER_POS];
          end
          2'b01:   statusReg <= XS_NEXT;
          default: statusReg <= XS_FAULT;
        endcase
      end
    end
  end

  // R5: a section keeps the virtual offset bits
  a_r5_section_offset: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDesc && memRspData[1:0] == 2'b10 |=>
      rspPa[OFFS_W-1:0] == vaReg[OFFS_W-1:0] && rspStatus == 2'b00);

  // R7: fault descriptors give a zero address
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDesc && (memRspData[1:0] == 2'b00 || memRspData[1:0] == 2'b11) |=>
      rspPa == '0 && rspStatus == 2'b10);

endmodule

// File: rtl/sect_xlate_walker.sv
module sect_xlate_walker
  import xw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFS_W    = 20,
  parameter int CACHE_POS = 3,
  parameter int SUPER_POS = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlateEn,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVa,
  output logic              memRdValid,
  input  logic              memRdReady,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPa,
  output logic [1:0]        rspStatus,
  output logic              rspCacheable,
  output logic              rspSuper
);

  xwStrobe_t stb;

  xw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .xlateEn(xlateEn),
    .baseWrEn(baseWrEn), .memRdReady(memRdReady), .memRspValid(memRspValid),
    .rspReady(rspReady), .reqReady(reqReady), .memRdValid(memRdValid),
    .rspValid(rspValid), .stb(stb)
  );

  xw_datapath #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .CACHE_POS(CACHE_POS), .SUPER_POS(SUPER_POS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVa(reqVa), .baseWrData(baseWrData),
    .memRspData(memRspData), .memRdAddr(memRdAddr), .rspPa(rspPa),
    .rspStatus(rspStatus), .rspCacheable(rspCacheable), .rspSuper(rspSuper)
  );

  // R9: read request holds until taken
  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdReady |=> memRdValid && $stable(memRdAddr));

  // R10: result holds until taken
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspPa) && $stable(rspStatus)
      && $stable(rspCacheable) && $stable(rspSuper));

  // R9: no new request while a result waits
  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady && !memRdValid);

endmodule

// File: tb/tb_sect_xlate_walker.sv
`timescale 1ns/1ps
module tb_sect_xlate_walker;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xlateEn = 1'b0, baseWrEn = 1'b0, reqValid = 1'b0;
  logic [31:0] baseWrData = '0, reqVa = '0;
  logic memRdReady = 1'b0, memRspValid = 1'b0, rspReady = 1'b0;
  logic [31:0] memRspData = '0;
  logic reqReady, memRdValid, rspValid, rspCacheable, rspSuper;
  logic [31:0] memRdAddr, rspPa;
  logic [1:0] rspStatus;

  always #2.5 clk = ~clk;

  sect_xlate_walker dut (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .memRdValid(memRdValid), .memRdReady(memRdReady),
    .memRdAddr(memRdAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPa(rspPa),
    .rspStatus(rspStatus), .rspCacheable(rspCacheable), .rspSuper(rspSuper)
  );

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  st;
    logic        c;
    logic        s;
    logic        fetch;
    logic [31:0] addr;
    int          fetchCnt;
  } exp_t;

  exp_t sbQ[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] baseModel = '0;
  int checks = 0, fails = 0, expFetch = 0, fetchCnt = 0, cyc = 0;
  logic [31:0] lastAddr = '0;
  bit reported = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: ready stalls every third cycle, data one cycle after acceptance
  always @(negedge clk) begin
    cyc++;
    memRdReady = (cyc % 3) != 0;
  end
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memRdValid && memRdReady) begin
      memRspValid <= 1'b1;
      memRspData  <= rdMem(memRdAddr);
      lastAddr    <= memRdAddr;
      fetchCnt    <= fetchCnt + 1;
    end
  end

  // monitor: consumer stalls in a pattern, compares against the scoreboard
  logic holdSeen = 1'b0;
  logic [31:0] holdPa;
  logic [1:0] holdSt;
  always @(negedge clk) begin
    if (rstN) begin
      if (holdSeen && rspValid) begin
        check(rspPa == holdPa && rspStatus == holdSt, "R10 hold", rspPa, holdPa);
      end
      rspReady = (cyc % 4) != 1;
      holdSeen = rspValid && !rspReady;
      holdPa = rspPa;
      holdSt = rspStatus;
      if (rspValid && rspReady) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R9 unexpected response", rspPa, 32'h0);
        end else begin
          exp_t e;
          e = sbQ.pop_front();
          check(rspPa == e.pa, "R1/R5/R6/R7 pa", rspPa, e.pa);
          check(rspStatus == e.st, "R5/R6/R7 status", {30'h0, rspStatus}, {30'h0, e.st});
          check(rspCacheable == e.c && rspSuper == e.s, "R8 attributes",
                {30'h0, rspCacheable, rspSuper}, {30'h0, e.c, e.s});
          check(fetchCnt == e.fetchCnt, "R1 read count", fetchCnt, e.fetchCnt);
          if (e.fetch) check(lastAddr == e.addr, "R2/R3/R4 read address", lastAddr, e.addr);
        end
      end
    end
  end

  function automatic exp_t expFor(input logic [31:0] va, input logic en);
    exp_t e;
    logic [31:0] d;
    e.fetch = en;
    e.addr = (baseModel & ~32'h3FFF) + ((va >> 20) << 2);
    e.fetchCnt = expFetch;
    e.c = 0; e.s = 0; e.pa = 0;
    if (!en) begin
      e.pa = va; e.st = 2'b00; e.c = 1;
    end else begin
      d = rdMem(e.addr);
      case (d[1:0])
        2'b10: begin e.st = 2'b00; e.pa = {d[31:20], va[19:0]}; e.c = d[3]; e.s = d[18]; end
        2'b01: e.st = 2'b01;
        default: e.st = 2'b10;
      endcase
    end
    return e;
  endfunction

  task automatic writeBase(input logic [31:0] v);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    baseWrEn = 1; baseWrData = v;
    @(negedge clk);
    baseWrEn = 0;
    baseModel = v & ~32'h3FFF;  // R3
  endtask

  task automatic sendReq(input logic [31:0] va, input logic en, input bit midWr, input logic [31:0] midVal);
    exp_t e;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    if (en) expFetch++;
    e = expFor(va, en);
    sbQ.push_back(e);
    reqValid = 1; reqVa = va; xlateEn = en;
    @(negedge clk);
    reqValid = 0;
    check(reqReady == 1'b0, "R9 ready low after accept", {31'h0, reqReady}, 32'h0);
    if (midWr) begin
      baseWrEn = 1; baseWrData = midVal;  // R4: ignored while busy
      @(negedge clk);
      baseWrEn = 0;
    end
    while (!reqReady) @(negedge clk);
  endtask

  initial begin
    mem[32'h0000448C] = 32'hABC00002;
    mem[32'h00004000 + (32'h7FF << 2)] = 32'h0014400A;
    mem[32'h00004000 + (32'h300 << 2)] = 32'h55500001;
    mem[32'h00004000 + (32'h301 << 2)] = 32'h66600000;
    mem[32'h00004000 + (32'h302 << 2)] = 32'h77700003;
    mem[32'h00004000] = 32'h80000002;
    mem[32'h00083FFC] = 32'hFED00006;
    mem[32'h00080000] = 32'h12300002;
    repeat (3) @(negedge clk);
    check(reqReady == 1 && rspValid == 0 && memRdValid == 0, "R9 reset state",
          {29'h0, reqReady, rspValid, memRdValid}, 32'h4);
    rstN = 1;
    writeBase(32'h00004000);
    sendReq(32'h12345678, 1, 0, 0);        // R2 R5 example
    sendReq(32'hDEADBEEF, 0, 0, 0);        // R1 bypass
    sendReq(32'h7FF12345, 1, 0, 0);        // R8 cacheable and super bits
    sendReq(32'h300ABCDE, 1, 0, 0);        // R6 second level
    sendReq(32'h30100001, 1, 0, 0);        // R7 type 00
    sendReq(32'h302FFFFF, 1, 1, 32'h00080000); // R7 type 11, R4 mid write
    sendReq(32'h000FFFFF, 1, 0, 0);        // R2 index 0, base unchanged (R4)
    writeBase(32'h00083FFF);               // R3 low bits cleared
    sendReq(32'hFFF00010, 1, 0, 0);        // R3 last index
    sendReq(32'h000C0FFE, 1, 0, 0);        // R3 first index of new table
    sendReq(32'h00000000, 0, 0, 0);        // R1 bypass zero
    while (sbQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #200000;
    check(1'b0, "watchdog", 32'h0, 32'h1);
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

endmodule